// File: doc/BRIEF.md
# Double-Width Sequential Integer Divider

This block divides a dividend twice as wide as its results by a single-width divisor. It works one quotient bit per clock, using the restoring method. The dividend is presented as two N-bit halves, with the upper half on `dvd_hi` and the lower half on `dvd_lo`. The block returns an N-bit quotient on `res_lo` and an N-bit remainder on `res_hi`. Unsigned and signed two's-complement division are both supported. In signed mode the operands are reduced to magnitudes, divided, and then given their signs back.

A third operation fills the upper half with copies of the lower half's sign bit. This prepares a single-width signed value for use as a signed double-width dividend. The caller pulses `start` with the operands and an operation code, watches `busy`, and collects the results when `done` pulses. A zero divisor and a quotient too wide for N bits are both reported on `err`, and the result registers are then left as they were.

Top module: `wide_divider`

## Requirements
- R1: With `op` = 2'b00 (unsigned), the dividend is {`dvd_hi`,`dvd_lo`}. When no error occurs, `res_lo` takes floor(dividend/`dvsr`) and `res_hi` takes the remainder.
- R2: With `op` = 2'b01 (signed), both operands are two's complement. The quotient is truncated toward zero and the remainder carries the dividend's sign. For example, -100/7 gives -14 and remainder -2.
- R3: In unsigned mode, a quotient that exceeds 2^N-1 asserts `err`. This happens exactly when `dvd_hi` >= `dvsr`.
- R4: In signed mode, a quotient outside [-2^(N-1), 2^(N-1)-1] asserts `err`.
- R5: A division (`op[1]`=0) by `dvsr` = 0 asserts `err`. `err` is valid in the `done` cycle and stays set until the next start is accepted.
- R6: Whenever `err` is reported, `res_hi` and `res_lo` keep the values they held before the operation.
- R7: With `op[1]`=1 (sign-extend), `res_lo` takes `dvd_lo` and every bit of `res_hi` takes `dvd_lo[N-1]`. Both `dvsr` and `dvd_hi` are ignored, and `err` stays low.
- R8: `done` is high for exactly one cycle. For a division with a nonzero divisor, it rises 2N+1 cycles after the cycle in which `start` is sampled. For a zero divisor or a sign-extend, it rises one cycle after that cycle.
- R9: `busy` is high from the cycle after acceptance up to, but not including, the `done` cycle. A `start` seen while `busy` is high is ignored.
- R10: A `start` in the `done` cycle is accepted, so operations can run back to back.
- R11: After reset, `busy`, `done`, `err`, `res_hi` and `res_lo` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a new operation |
| op | input | 2 | 00 unsigned divide, 01 signed divide, 1x sign-extend |
| dvd_hi | input | N | Upper half of dividend |
| dvd_lo | input | N | Lower half of dividend |
| dvsr | input | N | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Divide by zero or quotient overflow |
| res_hi | output | N | Remainder, or sign fill for sign-extend |
| res_lo | output | N | Quotient, or low half for sign-extend |

## Verification
Completion and acceptance can meet in one cycle. The cycle in which `done` pulses is also a cycle in which a new `start` is taken. The sweeps issue each next operation in exactly that cycle, and every result is checked against arithmetic computed in the bench, together with its latency. A second test presents `start` with different operands while a division is running. It expects the first operation's result, an unchanged latency, and no extra `done` pulse.

// File: rtl/wdiv_pkg.sv
// Shared types for the double-width divider.
package wdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } wdiv_state_t;
endpackage

// File: rtl/wdiv_prep.sv
// Operand conditioning: turns the dividend and divisor into magnitudes and
// records the signs of quotient and remainder. Assumes is_signed is low for
// unsigned and sign-extend operations, so the raw operands pass through unchanged.
module wdiv_prep #(
    parameter int N = 32
) (
    input  logic [N-1:0]   hi,
    input  logic [N-1:0]   lo,
    input  logic [N-1:0]   dvsr,
    input  logic           is_signed,
    output logic [2*N-1:0] dvd_mag,
    output logic [N-1:0]   dvsr_mag,
    output logic           q_neg,
    output logic           r_neg
);
    logic [2*N-1:0] full;
    logic           neg_d;
    logic           neg_s;

    // Compute the magnitudes and the result sign flags
    always_comb begin
        full     = {hi, lo};
        neg_d    = is_signed & hi[N-1];
        neg_s    = is_signed & dvsr[N-1];
        dvd_mag  = neg_d ? -full : full;
        dvsr_mag = neg_s ? -dvsr : dvsr;
        q_neg    = neg_d ^ neg_s;
        r_neg    = neg_d;
    end
endmodule

// File: rtl/wdiv_step.sv
// Restoring division datapath: one quotient bit per step over a 2N-bit
// dividend. Assumes the divisor is nonzero whenever step is asserted.
module wdiv_step #(
    parameter int N = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [2*N-1:0] dvd_mag,
    input  logic [N-1:0]   dvsr_mag,
    output logic [2*N-1:0] qmag,
    output logic [N-1:0]   rmag
);
    logic [2*N-1:0] dq;
    logic [N-1:0]   rem;
    logic [N-1:0]   dvs;
    logic [N:0]     shifted;
    logic [N:0]     diff;
    logic           take;

    // Trial subtraction of the divisor from the shifted partial remainder
    always_comb begin
        shifted = {rem, dq[2*N-1]};
        diff    = shifted - {1'b0, dvs};
        take    = (shifted >= {1'b0, dvs});
    end

    // Load operands or advance one iteration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq  <= '0;
            rem <= '0;
            dvs <= '0;
        end else if (load) begin
            dq  <= dvd_mag;
            rem <= '0;
            dvs <= dvsr_mag;
        end else if (step) begin
            dq  <= {dq[2*N-2:0], take};
            rem <= take ? diff[N-1:0] : shifted[N-1:0];
        end
    end

    assign qmag = dq;
    assign rmag = rem;

    // R1: the partial remainder always stays below the divisor while iterating
    a_r1_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (rem < dvs));
endmodule

// File: rtl/wdiv_fix.sv
// Result fix-up: applies signs to quotient and remainder magnitudes and
// decides whether the quotient fits in N bits for the selected mode.
module wdiv_fix #(
    parameter int N = 32
) (
    input  logic [2*N-1:0] qmag,
    input  logic [N-1:0]   rmag,
    input  logic           is_signed,
    input  logic           q_neg,
    input  logic           r_neg,
    output logic [N-1:0]   quo,
    output logic [N-1:0]   rem,
    output logic           ovf
);
    localparam logic [2*N-1:0] SLIM = {{N{1'b0}}, 1'b1, {(N-1){1'b0}}};

    // Decide overflow and apply signs
    always_comb begin
        if (is_signed)
            ovf = q_neg ? (qmag > SLIM) : (qmag >= SLIM);
        else
            ovf = |qmag[2*N-1:N];
        quo = q_neg ? -qmag[N-1:0] : qmag[N-1:0];
        rem = r_neg ? -rmag : rmag;
    end
endmodule

// File: rtl/wide_divider.sv
// Double-width sequential divider top: start/busy/done control, error
// detection and result registers. Assumes operands are stable in the
// cycle start is sampled; they are captured at that edge.
module wide_divider
    import wdiv_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [N-1:0] dvd_hi,
    input  logic [N-1:0] dvd_lo,
    input  logic [N-1:0] dvsr,
    output logic         busy,
    output logic         done,
    output logic         err,
    output logic [N-1:0] res_hi,
    output logic [N-1:0] res_lo
);
    localparam int ITER = 2 * N;
    localparam int CW   = $clog2(ITER);

    wdiv_state_t    state;
    logic [CW-1:0]  cnt;
    logic           sgn_r, qneg_r, rneg_r, sext_r, zero_r;
    logic           in_signed, load;
    logic [2*N-1:0] dvd_mag, qmag;
    logic [N-1:0]   dvsr_mag, rmag, quo, rem;
    logic           q_neg, r_neg, ovf;

    assign in_signed = ~op[1] & op[0];
    assign load      = (state == ST_IDLE) && start;
    assign busy      = (state != ST_IDLE);

    wdiv_prep #(.N(N)) prep_i (
        .hi(dvd_hi), .lo(dvd_lo), .dvsr(dvsr), .is_signed(in_signed),
        .dvd_mag(dvd_mag), .dvsr_mag(dvsr_mag), .q_neg(q_neg), .r_neg(r_neg)
    );

    wdiv_step #(.N(N)) step_i (
        .clk(clk), .rst_n(rst_n), .load(load), .step(state == ST_RUN),
        .dvd_mag(dvd_mag), .dvsr_mag(dvsr_mag), .qmag(qmag), .rmag(rmag)
    );

    wdiv_fix #(.N(N)) fix_i (
        .qmag(qmag), .rmag(rmag), .is_signed(sgn_r), .q_neg(qneg_r),
        .r_neg(rneg_r), .quo(quo), .rem(rem), .ovf(ovf)
    );

    // Control sequence, error flag and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sgn_r  <= 1'b0;
            qneg_r <= 1'b0;
            rneg_r <= 1'b0;
            sext_r <= 1'b0;
            zero_r <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
            res_hi <= '0;
            res_lo <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    err    <= 1'b0;
                    cnt    <= '0;
                    sgn_r  <= in_signed;
                    qneg_r <= q_neg;
                    rneg_r <= r_neg;
                    sext_r <= op[1];
                    zero_r <= ~op[1] & (dvsr == '0);
                    state  <= (op[1] || dvsr == '0) ? ST_FIX : ST_RUN;
                end
                ST_RUN: begin
                    cnt <= cnt + CW'(1);
                    if (cnt == CW'(ITER - 1))
                        state <= ST_FIX;
                end
                default: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                    if (sext_r) begin
                        res_hi <= {N{qmag[N-1]}};
                        res_lo <= qmag[N-1:0];
                    end else if (zero_r || ovf) begin
                        err <= 1'b1;
                    end else begin
                        res_hi <= rem;
                        res_lo <= quo;
                    end
                end
            endcase
        end
    end

    // R8: done lasts a single cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: busy only drops in the done cycle
    a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R9: busy only rises after an accepted start
    a_r9_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R5: a zero divisor ends in an error
    a_r5_zero_flags_err: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIX && zero_r) |=> (err && done));
    // R6: results are untouched when an error is reported
    a_r6_hold_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> ($stable(res_hi) && $stable(res_lo)));
    // R7: sign-extend never reports an error
    a_r7_sext_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIX && sext_r) |=> !err);
endmodule

// File: tb/wide_divider_tb_top.sv
`timescale 1ns/1ps
module wide_divider_tb_top;
    localparam int N = 4;
    localparam int M = 1 << N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   op = 2'b00;
    logic [N-1:0] dvd_hi = '0, dvd_lo = '0, dvsr = '0;
    logic         busy, done, err;
    logic [N-1:0] res_hi, res_lo;

    int n_chk = 0;
    int n_fail = 0;
    int held_hi = 0;
    int held_lo = 0;

    always #4 clk = ~clk;

    wide_divider #(.N(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvsr(dvsr),
        .busy(busy), .done(done), .err(err), .res_hi(res_hi), .res_lo(res_lo)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue one operation at a negedge; return at the negedge where done is seen.
    task automatic do_op(input int o, input int hi, input int lo, input int dv,
                         input bit e_err, input int e_hi, input int e_lo,
                         input int e_lat, input string req);
        int w;
        op = o[1:0]; dvd_hi = hi[N-1:0]; dvd_lo = lo[N-1:0]; dvsr = dv[N-1:0];
        start = 1'b1;
        w = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            w++;
            if (!done && w > 1) chk(busy == 1'b1, "R9 busy while running", busy, 1);
        end while (!done && w < 100);
        chk(w == e_lat, "R8 R10 latency", w, e_lat);
        chk(busy == 1'b0, "R9 busy low at done", busy, 0);
        chk(err == e_err, {req, " err"}, err, e_err);
        chk(int'(res_hi) == e_hi, {req, " res_hi"}, res_hi, e_hi);
        chk(int'(res_lo) == e_lo, {req, " res_lo"}, res_lo, e_lo);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(busy == 0 && done == 0 && err == 0, "R11 flags", {busy, done, err}, 0);
        chk(res_hi == 0 && res_lo == 0, "R11 results", {res_hi, res_lo}, 0);

        // Unsigned sweep (R1, R3, R5, R6)
        for (int hi = 0; hi < M; hi++)
            for (int lo = 0; lo < M; lo++)
                for (int dv = 0; dv < M; dv++) begin
                    int dd, q, r;
                    dd = hi * M + lo;
                    if (dv == 0)
                        do_op(0, hi, lo, dv, 1, held_hi, held_lo, 2, "R5 R6 udiv zero");
                    else begin
                        q = dd / dv; r = dd % dv;
                        if (q >= M)
                            do_op(0, hi, lo, dv, 1, held_hi, held_lo, 2*N+2, "R3 R6 udiv ovf");
                        else begin
                            held_hi = r; held_lo = q;
                            do_op(0, hi, lo, dv, 0, r, q, 2*N+2, "R1 udiv");
                        end
                    end
                end

        // Signed sweep (R2, R4, R5, R6)
        for (int hi = 0; hi < M; hi++)
            for (int lo = 0; lo < M; lo++)
                for (int dv = 0; dv < M; dv++) begin
                    int sd, sv, q, r;
                    sd = hi * M + lo;
                    if (sd >= M*M/2) sd = sd - M*M;
                    sv = (dv >= M/2) ? dv - M : dv;
                    if (sv == 0)
                        do_op(1, hi, lo, dv, 1, held_hi, held_lo, 2, "R5 R6 sdiv zero");
                    else begin
                        q = sd / sv; r = sd % sv;
                        if (q > M/2 - 1 || q < -(M/2))
                            do_op(1, hi, lo, dv, 1, held_hi, held_lo, 2*N+2, "R4 R6 sdiv ovf");
                        else begin
                            held_hi = r & (M-1); held_lo = q & (M-1);
                            do_op(1, hi, lo, dv, 0, held_hi, held_lo, 2*N+2, "R2 sdiv");
                        end
                    end
                end

        // Sign-extend sweep (R7), divisor and high half ignored
        for (int lo = 0; lo < M; lo++) begin
            held_lo = lo;
            held_hi = (lo >= M/2) ? M-1 : 0;
            do_op(2 + (lo & 1), lo ^ 5, lo, 0, 0, held_hi, held_lo, 2, "R7 sext");
        end

        // R8: no done in the cycle after done
        @(negedge clk);
        chk(done == 1'b0, "R8 done single", done, 0);

        // R9: start while busy is ignored
        op = 2'b00; dvd_hi = 4'd0; dvd_lo = 4'd13; dvsr = 4'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        op = 2'b00; dvd_hi = 4'd0; dvd_lo = 4'd15; dvsr = 4'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            int w;
            w = 4;
            while (!done && w < 100) begin
                @(negedge clk);
                w++;
            end
            chk(w == 2*N+2, "R9 latency unaffected", w, 2*N+2);
        end
        chk(res_lo == 4 && res_hi == 1, "R9 first result kept", {res_hi, res_lo}, 8'h14);
        begin
            int extra;
            extra = 0;
            repeat (12) begin
                @(negedge clk);
                if (done || busy) extra++;
            end
            chk(extra == 0, "R9 second start dropped", extra, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule